// File: doc/BRIEF.md
# Hypotenuse Length Estimator

This block estimates the length of the hypotenuse of a right triangle whose two legs are unsigned integers. It uses only comparison, shifts and one adder/subtractor, and needs no multiplier or square-root unit. With `x` the larger leg and `y` the smaller, the estimate is the larger of `x` and `x - x/8 + y/2`. The divisions are logical right shifts, so they truncate toward zero.

A hardwired controller steps a small datapath through a fixed chain of register transfers, one per clock. The datapath has four working registers, a min/max unit, a right shifter with two shift distances and an add/subtract unit. The user pulses `start_i` for one clock and holds `a_i` and `b_i` steady until the run ends. A successful run ends with a one-clock `done_o` pulse and the result on `c_o`. If the final addition overflows the register width, the run ends with a one-clock `err_o` pulse instead.

Top module: `hyp_est`

## Requirements
- R1: During and right after a synchronous active-low reset, `done_o` and `err_o` are 0 and `c_o` is 0.
- R2: On a successful run, when `done_o` is 1, `c_o` equals max(x, x - floor(x/8) + floor(y/2)), where x = max(a_i,b_i) and y = min(a_i,b_i).
- R3: `done_o` is high for exactly one clock, 8 clocks after the rising edge that samples `start_i` high (the 8th falling edge after that rising edge).
- R4: If x - floor(x/8) + floor(y/2) exceeds 2^W-1, `err_o` pulses high for exactly one clock, 7 clocks after the start edge, `done_o` stays low for that run, and the block then returns to idle.
- R5: After an overflow run, `c_o` keeps the result of the last successful run.
- R6: A high `start_i` while a run is in progress, including the clock of the `done_o` pulse, neither restarts nor extends the run and does not start a new one.
- R7: Both shifts are logical (zero fill), so legs of 2^(W-1) or more give the same result as the unsigned formula in R2.
- R8: While idle with `start_i` low, neither `done_o` nor `err_o` is ever raised.
- R9: The result does not depend on which input carries the larger leg: swapping `a_i` and `b_i` gives the same `c_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-clock request to begin a run, honoured only when idle |
| a_i | input | W | First leg, unsigned, held steady for the whole run |
| b_i | input | W | Second leg, unsigned, held steady for the whole run |
| c_o | output | W | Last successful estimate |
| done_o | output | 1 | One-clock pulse marking a successful run |
| err_o | output | 1 | One-clock pulse marking an overflow run |

## Verification
The bench targets the overflow boundary: pairs whose sum lands just below and just above 2^W-1. A design that checked the subtract carry, or that skipped the overflow test, would raise `err_o` on legal pairs or report a wrapped, too-small result. Legs with the top bit set catch arithmetic shifts, which would sign-fill and give wrong values. Mirrored input pairs catch a min/max unit with its outputs swapped. Extra `start_i` pulses sent mid-run and during the `done_o` clock would show a controller that restarts, double-pulses or leaves idle without a request. A run that ends in an error is followed by a check that `c_o` was not overwritten.

// File: rtl/hyp_pkg.sv
// Package: shared controller state encoding and datapath control word for
// the hypotenuse estimator. Assumes W-bit unsigned operands throughout.
package hyp_pkg;

    // Shift distances used for y/2 and x/8.
    localparam int SHIFT_NEAR = 1;
    localparam int SHIFT_FAR  = 3;

    // One state per register transfer, plus idle, completion and fault.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TAKE_MAX,
        ST_TAKE_MIN,
        ST_HALVE_Y,
        ST_EIGHTH_X,
        ST_SEVEN_EIGHTHS,
        ST_SUM,
        ST_PICK,
        ST_DONE,
        ST_FAULT
    } hyp_state_e;

    // Control word from the controller to the datapath.
    typedef struct packed {
        logic ld_x;          // load Rx
        logic ld_y;          // load Ry
        logic ld_t;          // load Rt
        logic ld_c;          // load Rc
        logic cmp_regs;      // min/max compares Rx,Rt (1) or a,b (0)
        logic y_from_shift;  // Ry takes shifter (1) or min output (0)
        logic t_from_alu;    // Rt takes add/sub result (1) or shifter (0)
        logic shf_src_x;     // shifter input is Rx (1) or Ry (0)
        logic shf_far;       // shift by SHIFT_FAR (1) or SHIFT_NEAR (0)
        logic alu_a_is_y;    // add/sub left operand is Ry (1) or Rx (0)
        logic alu_sub;       // subtract (1) or add (0)
    } hyp_ctl_t;

endpackage

// File: rtl/hyp_minmax.sv
// Module: hyp_minmax
// Purely combinational unsigned min/max of two W-bit values.
// Assumes: unsigned operands; ties give the same value on both outputs.
module hyp_minmax #(
    parameter int W = 8
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] q_i,
    output logic [W-1:0] max_o,
    output logic [W-1:0] min_o
);

    logic p_larger;

    // Compare once and steer both outputs from the same decision.
    always_comb begin
        p_larger = (p_i >= q_i);
        max_o    = p_larger ? p_i : q_i;
        min_o    = p_larger ? q_i : p_i;
    end

    always_comb begin
        AST_MINMAX_ORDER: assert (max_o >= min_o); // R9
    end

endmodule

// File: rtl/hyp_shifter.sv
// Module: hyp_shifter
// Logical right shift by one of two fixed distances chosen by far_i.
// Assumes: NEAR and FAR are both below W; vacated bits fill with zero.
module hyp_shifter #(
    parameter int W    = 8,
    parameter int NEAR = 1,
    parameter int FAR  = 3
) (
    input  logic [W-1:0] d_i,
    input  logic         far_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] near_q;
    logic [W-1:0] far_q;

    // Build both fixed shifts as wiring, with zero fill in the top bits.
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i + NEAR < W) begin : g_near_src
                assign near_q[i] = d_i[i+NEAR];
            end else begin : g_near_zero
                assign near_q[i] = 1'b0;
            end
            if (i + FAR < W) begin : g_far_src
                assign far_q[i] = d_i[i+FAR];
            end else begin : g_far_zero
                assign far_q[i] = 1'b0;
            end
        end
    endgenerate

    // Select the requested distance.
    always_comb begin
        q_o = far_i ? far_q : near_q;
    end

endmodule

// File: rtl/hyp_addsub.sv
// Module: hyp_addsub
// W-bit unsigned adder/subtractor. ovf_o flags an add whose true sum does
// not fit in W bits. Assumes: the subtract is only used where a >= b, so
// the subtract borrow is not reported.
module hyp_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o,
    output logic         ovf_o
);

    logic [W:0] wide;

    // Compute in W+1 bits so the carry of the add is visible.
    always_comb begin
        if (sub_i) begin
            wide = {1'b0, a_i} - {1'b0, b_i};
        end else begin
            wide = {1'b0, a_i} + {1'b0, b_i};
        end
        y_o   = wide[W-1:0];
        ovf_o = !sub_i && wide[W];
    end

endmodule

// File: rtl/hyp_datapath.sv
// Module: hyp_datapath
// Working registers Rx, Ry, Rt, Rc with operand multiplexers, min/max,
// shifter and add/subtract unit. Every transfer is selected by the control
// word. Assumes: a_i and b_i are steady while a run is in progress.
module hyp_datapath
    import hyp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  hyp_ctl_t      ctl_i,
    output logic          ovf_o,
    output logic [W-1:0]  c_o
);

    logic [W-1:0] rx_q, ry_q, rt_q, rc_q;
    logic [W-1:0] cmp_p, cmp_q, cmp_max, cmp_min;
    logic [W-1:0] shf_in, shf_out;
    logic [W-1:0] alu_a, alu_y;

    // Operand selection for the min/max unit, the shifter and the adder.
    always_comb begin
        cmp_p  = ctl_i.cmp_regs   ? rx_q : a_i;
        cmp_q  = ctl_i.cmp_regs   ? rt_q : b_i;
        shf_in = ctl_i.shf_src_x  ? rx_q : ry_q;
        alu_a  = ctl_i.alu_a_is_y ? ry_q : rx_q;
    end

    hyp_minmax #(.W(W)) u_minmax (
        .p_i   (cmp_p),
        .q_i   (cmp_q),
        .max_o (cmp_max),
        .min_o (cmp_min)
    );

    hyp_shifter #(.W(W), .NEAR(SHIFT_NEAR), .FAR(SHIFT_FAR)) u_shift (
        .d_i   (shf_in),
        .far_i (ctl_i.shf_far),
        .q_o   (shf_out)
    );

    hyp_addsub #(.W(W)) u_alu (
        .a_i   (alu_a),
        .b_i   (rt_q),
        .sub_i (ctl_i.alu_sub),
        .y_o   (alu_y),
        .ovf_o (ovf_o)
    );

    // Register file: load each register when its enable is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
            ry_q <= '0;
            rt_q <= '0;
            rc_q <= '0;
        end else begin
            if (ctl_i.ld_x) rx_q <= cmp_max;
            if (ctl_i.ld_y) ry_q <= ctl_i.y_from_shift ? shf_out : cmp_min;
            if (ctl_i.ld_t) rt_q <= ctl_i.t_from_alu ? alu_y : shf_out;
            if (ctl_i.ld_c) rc_q <= cmp_max;
        end
    end

    assign c_o = rc_q;

    AST_Y_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.ld_y && ctl_i.y_from_shift) |=> (ry_q[W-1] == 1'b0)); // R7
    AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.ld_t && ctl_i.alu_sub) |-> (rx_q >= rt_q)); // R2
    AST_RESULT_NOT_BELOW_X: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.ld_c |=> (rc_q >= rx_q)); // R2

endmodule

// File: rtl/hyp_ctrl.sv
// Module: hyp_ctrl
// Hardwired sequencer. It leaves idle on start_i, walks the transfer chain
// one state per clock, branches to the fault state on add overflow and
// returns to idle after the done or fault state. Outputs depend on the
// state only, except the overflow branch. Assumes ovf_i is valid in ST_SUM.
module hyp_ctrl
    import hyp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ovf_i,
    output hyp_ctl_t   ctl_o,
    output logic       done_o,
    output logic       err_o
);

    hyp_state_e state_q, state_d;

    // Next-state selection along the fixed chain.
    always_comb begin
        unique case (state_q)
            ST_IDLE:          state_d = start_i ? ST_TAKE_MAX : ST_IDLE;
            ST_TAKE_MAX:      state_d = ST_TAKE_MIN;
            ST_TAKE_MIN:      state_d = ST_HALVE_Y;
            ST_HALVE_Y:       state_d = ST_EIGHTH_X;
            ST_EIGHTH_X:      state_d = ST_SEVEN_EIGHTHS;
            ST_SEVEN_EIGHTHS: state_d = ST_SUM;
            ST_SUM:           state_d = ovf_i ? ST_FAULT : ST_PICK;
            ST_PICK:          state_d = ST_DONE;
            ST_DONE:          state_d = ST_IDLE;
            ST_FAULT:         state_d = ST_IDLE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Decode the state into the datapath control word.
    always_comb begin
        ctl_o = '0;
        unique case (state_q)
            ST_TAKE_MAX: begin
                ctl_o.ld_x = 1'b1;
            end
            ST_TAKE_MIN: begin
                ctl_o.ld_y = 1'b1;
            end
            ST_HALVE_Y: begin
                ctl_o.ld_y         = 1'b1;
                ctl_o.y_from_shift = 1'b1;
            end
            ST_EIGHTH_X: begin
                ctl_o.ld_t      = 1'b1;
                ctl_o.shf_src_x = 1'b1;
                ctl_o.shf_far   = 1'b1;
            end
            ST_SEVEN_EIGHTHS: begin
                ctl_o.ld_t       = 1'b1;
                ctl_o.t_from_alu = 1'b1;
                ctl_o.alu_sub    = 1'b1;
            end
            ST_SUM: begin
                ctl_o.ld_t       = 1'b1;
                ctl_o.t_from_alu = 1'b1;
                ctl_o.alu_a_is_y = 1'b1;
            end
            ST_PICK: begin
                ctl_o.ld_c     = 1'b1;
                ctl_o.cmp_regs = 1'b1;
            end
            default: ctl_o = '0;
        endcase
    end

    // Completion flags are plain state decodes.
    assign done_o = (state_q == ST_DONE);
    assign err_o  = (state_q == ST_FAULT);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R4
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R4
    AST_ERR_FROM_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(state_q) == ST_SUM)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_i) |=> (state_q == ST_IDLE)); // R8
    AST_DONE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state_q == ST_IDLE)); // R6

endmodule

// File: rtl/hyp_est.sv
// Module: hyp_est (top)
// Hypotenuse estimator: controller plus datapath. A one-clock start_i
// launches a run. done_o or err_o pulses once at its end.
// Assumes: a_i and b_i are held steady from the start clock until the end.
module hyp_est #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] c_o,
    output logic         done_o,
    output logic         err_o
);

    hyp_pkg::hyp_ctl_t ctl;
    logic              ovf;

    hyp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .ovf_i   (ovf),
        .ctl_o   (ctl),
        .done_o  (done_o),
        .err_o   (err_o)
    );

    hyp_datapath #(.W(W)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (a_i),
        .b_i   (b_i),
        .ctl_i (ctl),
        .ovf_o (ovf),
        .c_o   (c_o)
    );

    AST_ERR_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $stable(c_o)); // R5
    AST_DONE_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (c_o >= a_i && c_o >= b_i)); // R2

endmodule

// File: tb/hyp_est_tb.sv
module hyp_est_tb;

    localparam int W  = 8;
    localparam int NV = 16;

    // Vector fields: {a, b, expected c, expected overflow}.
    localparam logic [3*W:0] VEC [NV] = '{
        {8'd0,   8'd0,   8'd0,   1'b0},
        {8'd3,   8'd4,   8'd5,   1'b0},
        {8'd4,   8'd3,   8'd5,   1'b0},
        {8'd100, 8'd50,  8'd113, 1'b0},
        {8'd240, 8'd16,  8'd240, 1'b0},
        {8'd16,  8'd240, 8'd240, 1'b0},
        {8'd200, 8'd200, 8'd0,   1'b1},
        {8'd255, 8'd0,   8'd255, 1'b0},
        {8'd0,   8'd255, 8'd255, 1'b0},
        {8'd128, 8'd128, 8'd176, 1'b0},
        {8'd160, 8'd120, 8'd200, 1'b0},
        {8'd7,   8'd1,   8'd7,   1'b0},
        {8'd255, 8'd255, 8'd0,   1'b1},
        {8'd170, 8'd170, 8'd234, 1'b0},
        {8'd190, 8'd190, 8'd0,   1'b1},
        {8'd180, 8'd150, 8'd233, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [W-1:0] c_o;
    logic         done_o;
    logic         err_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hyp_est #(.W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .c_o     (c_o),
        .done_o  (done_o),
        .err_o   (err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Launch one run and watch 16 falling edges. A second start pulse is
    // sent at observation step extra (0 = none).
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input int extra, output int t_done, output int t_err,
                       output int n_done, output int c_at_done);
        t_done = 0; t_err = 0; n_done = 0; c_at_done = -1;
        @(negedge clk);
        a_i = a; b_i = b; start_i = 1'b1;
        for (int n = 1; n <= 16; n++) begin
            @(negedge clk);
            start_i = (n == extra);
            if (done_o) begin
                n_done++;
                if (t_done == 0) begin
                    t_done = n;
                    c_at_done = int'(c_o);
                end
            end
            if (err_o && t_err == 0) t_err = n;
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int td, te, nd, cd, last_c, idle_evt;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 done in reset", done_o, 0);
        chk("R1 err in reset", err_o, 0);
        chk("R1 c in reset", c_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 c after reset", c_o, 0);

        // R8: idle without start never completes
        idle_evt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done_o || err_o) idle_evt++;
        end
        chk("R8 idle events", idle_evt, 0);

        // Vector table: R2 values, R3/R4 timing, R5 hold, R7 and R9 pairs
        last_c = 0;
        for (int v = 0; v < NV; v++) begin
            logic [W-1:0] va, vb, vc;
            logic         verr;
            {va, vb, vc, verr} = VEC[v];
            run(va, vb, 0, td, te, nd, cd);
            if (verr) begin
                chk("R4 err time", te, 7);
                chk("R4 no done", nd, 0);
                chk("R5 c kept", c_o, last_c);
            end else begin
                chk("R3 done time", td, 8);
                chk("R3 done count", nd, 1);
                chk("R2 R7 R9 value", cd, vc);
                chk("R4 no err", te, 0);
                last_c = vc;
            end
        end

        // R6: extra start mid-run and during the done clock
        run(8'd3, 8'd4, 3, td, te, nd, cd);
        chk("R6 mid-run done time", td, 8);
        chk("R6 mid-run done count", nd, 1);
        chk("R6 mid-run value", cd, 5);
        run(8'd100, 8'd50, 8, td, te, nd, cd);
        chk("R6 at-done done count", nd, 1);
        chk("R6 at-done value", cd, 113);
        run(8'd200, 8'd200, 7, td, te, nd, cd);
        chk("R6 at-err count", nd, 0);
        chk("R6 c after err", c_o, 113);

        // R1: reset in the middle of a run
        @(negedge clk);
        a_i = 8'd160; b_i = 8'd120; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset c", c_o, 0);
        chk("R1 mid-run reset done", done_o, 0);
        rst_n = 1'b1;
        idle_evt = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done_o || err_o) idle_evt++;
        end
        chk("R8 after reset events", idle_evt, 0);
        run(8'd160, 8'd120, 0, td, te, nd, cd);
        chk("R2 after reset value", cd, 200);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule